// File: doc/BRIEF.md
# Paged Write Buffer with Column Rollover

The block sits between a serial bus front end and a nonvolatile storage model. It handles the write side of a transaction. When a transaction opens, the front end supplies a target and a word address. The target is either the memory array or the control-register section. Each data byte that follows is placed in a page buffer at the current column, and the column then steps forward by one. When the column reaches the end of the page, it returns to column 0 of the same page. A page holds 128 bytes for the array and 8 bytes for the control section.

Nothing is written to storage while bytes are arriving. When the stop arrives, the block decides whether the transaction may commit. If it may, the block streams every column loaded in that transaction to a commit port, one byte per cycle, in ascending column order.

Two rules can block a commit:
- Control registers only accept data after an unlock sequence written to a status register.
- Array pages that touch a configurable protected address range are never committed.

In both cases every byte is still acknowledged.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, ack_o, busy_o, cm_valid_o and lock_o are 0 and the unlock state is locked.
- R2: Each accepted byte advances col_o by one. The column wraps within the page of the current target: 128 columns when tgt_i=0 (array), 8 columns when tgt_i=1 (control). On start, the column loads from the low address bits, and the page base is the address with those bits cleared.
- R3: When more bytes arrive than the page holds, a later byte replaces the earlier byte at the same column. Each column is committed at most once, carrying its last value.
- R4: Only columns loaded in the current transaction are committed. They come out in ascending column order, with cm_addr_o equal to page base plus column and cm_tgt_o equal to the target.
- R5: No commit byte appears before stop_i ends the transaction.
- R6: A status write is a control transaction whose start address is STATUS_ADDR (default 0x03F); its first data byte is the value.
  - Value 0x02 moves the lock to step one.
  - Value 0x06 opens it only from step one.
  - Any other status value relocks it.
  - lock_o is 1 only while the lock is open.
  - Status writes always commit.
- R7: A non-status control write made while the lock is not open is acknowledged but commits nothing. The same write commits when the lock is open.
- R8: An array transaction that loaded any address inside the inclusive range [prot_lo_i, prot_hi_i] is acknowledged but commits nothing. The range is empty when prot_lo_i > prot_hi_i.
- R9: While busy_o is 1, start_i and byte_valid_i are ignored and not acknowledged. Bytes arriving with no open transaction are also ignored.
- R10: ack_o pulses one cycle after each accepted byte.
- R11: A transaction stopped with no data bytes commits nothing and does not raise busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a write transaction |
| tgt_i | input | 1 | Target at start: 0 array, 1 control section |
| addr_i | input | ADDR_W | Word address at start |
| byte_valid_i | input | 1 | Data byte present |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Ends the transaction |
| prot_lo_i | input | ADDR_W | Protected range low bound |
| prot_hi_i | input | ADDR_W | Protected range high bound |
| ack_o | output | 1 | Byte acknowledge |
| col_o | output | COL_W | Current page column |
| lock_o | output | 1 | Control-section writes enabled |
| busy_o | output | 1 | Commit in progress |
| cm_valid_o | output | 1 | Commit byte valid |
| cm_tgt_o | output | 1 | Commit target |
| cm_addr_o | output | ADDR_W | Commit address |
| cm_data_o | output | 8 | Commit data |

## Verification
Each result has a fixed delay after its stimulus:

| Result | Due |
|---|---|
| ack_o and col_o | One clock edge after the byte they answer |
| busy_o | The edge after stop |
| First commit byte | One cycle after the scan reaches its column |
| lock_o | The edge of the stop that closes a status write |

The bench drives inputs on falling edges and samples on the following falling edge. Each transaction waits for busy_o to drop, plus one extra cycle, before its logs are compared. The bench logs commits and acknowledges on every falling edge. Its expected page contents come from its own model of the column wrap.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_STEP1  = 2'd1,
    LK_OPEN   = 2'd2
  } lock_e;

  localparam logic TGT_ARR = 1'b0;
  localparam logic TGT_CTL = 1'b1;
endpackage

// File: rtl/pwb_col_ctr.sv
module pwb_col_ctr #(
  parameter int ARR_PG = 128,
  parameter int CTL_PG = 8,
  localparam int COL_W = $clog2(ARR_PG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tgt_i,
  input  logic             load_i,
  input  logic [COL_W-1:0] load_col_i,
  input  logic             adv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] mask, col_q;

  assign mask  = tgt_i ? COL_W'(CTL_PG - 1) : COL_W'(ARR_PG - 1);
  assign col_o = col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     col_q <= '0;
    else if (load_i) col_q <= load_col_i;
    else if (adv_i)  col_q <= (col_q + COL_W'(1)) & mask;
  end

  AST_COL_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_i && !load_i) |=> (col_q < COL_W'(CTL_PG))); // R2
endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int COL_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] wr_col_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [COL_W-1:0] rd_col_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_dirty_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] dirty_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_col
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      dirty_q[g] <= 1'b0;
      else if (clear_i)                                 dirty_q[g] <= 1'b0;
      else if (wr_i && wr_col_i == COL_W'(g))           dirty_q[g] <= 1'b1;
    end
    always_ff @(posedge clk_i) begin
      if (wr_i && wr_col_i == COL_W'(g)) mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o  = mem_q[rd_col_i];
  assign rd_dirty_o = dirty_q[rd_col_i];

  AST_WR_MARKS_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clear_i) |=> dirty_q[$past(wr_col_i)]); // R4
endmodule

// File: rtl/pwb_lock.sv
module pwb_lock
  import pwb_pkg::*;
#(
  parameter logic [7:0] KEY1 = 8'h02,
  parameter logic [7:0] KEY2 = 8'h06
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic [7:0] val_i,
  output lock_e      st_o
);
  lock_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LK_LOCKED;
    else if (upd_i) begin
      if (val_i == KEY1)                        st_q <= LK_STEP1;
      else if (val_i == KEY2 && st_q == LK_STEP1) st_q <= LK_OPEN;
      else                                      st_q <= LK_LOCKED;
    end
  end

  assign st_o = st_q;

  AST_OPEN_VIA_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LK_OPEN && $past(st_q) != LK_OPEN) |-> $past(st_q) == LK_STEP1); // R6
  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(st_q)); // R6
endmodule

// File: rtl/pwb_commit_scan.sv
module pwb_commit_scan #(
  parameter int ARR_PG = 128,
  parameter int ADDR_W = 12,
  localparam int COL_W = $clog2(ARR_PG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [COL_W-1:0]  last_col_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              tgt_i,
  output logic [COL_W-1:0]  rd_col_o,
  input  logic [7:0]        rd_data_i,
  input  logic              rd_dirty_i,
  output logic              busy_o,
  output logic              cm_valid_o,
  output logic              cm_tgt_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [7:0]        cm_data_o
);
  logic             scan_q, vld_q, tgt_q;
  logic [COL_W-1:0] idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]       data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_q <= 1'b0;
      idx_q  <= '0;
      vld_q  <= 1'b0;
      tgt_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      vld_q <= scan_q && rd_dirty_i;
      if (go_i) begin
        scan_q <= 1'b1;
        idx_q  <= '0;
      end else if (scan_q) begin
        tgt_q  <= tgt_i;
        addr_q <= base_i | ADDR_W'(idx_q);
        data_q <= rd_data_i;
        if (idx_q == last_col_i) scan_q <= 1'b0;
        else                     idx_q  <= idx_q + COL_W'(1);
      end
    end
  end

  assign rd_col_o   = idx_q;
  assign busy_o     = scan_q | vld_q;
  assign cm_valid_o = vld_q;
  assign cm_tgt_o   = tgt_q;
  assign cm_addr_o  = addr_q;
  assign cm_data_o  = data_q;

  AST_CM_AFTER_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_valid_o |-> $past(scan_q)); // R5
  AST_NO_GO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_o); // R9
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pwb_pkg::*;
#(
  parameter int          ARR_PG      = 128,
  parameter int          CTL_PG      = 8,
  parameter int          ADDR_W      = 12,
  parameter logic [11:0] STATUS_ADDR = 12'h03F,
  localparam int         COL_W       = $clog2(ARR_PG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tgt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] prot_lo_i,
  input  logic [ADDR_W-1:0] prot_hi_i,
  output logic              ack_o,
  output logic [COL_W-1:0]  col_o,
  output logic              lock_o,
  output logic              busy_o,
  output logic              cm_valid_o,
  output logic              cm_tgt_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [7:0]        cm_data_o
);
  localparam logic [COL_W-1:0] ARR_LAST = COL_W'(ARR_PG - 1);
  localparam logic [COL_W-1:0] CTL_LAST = COL_W'(CTL_PG - 1);

  logic              active_q, tgt_q, any_q, hit_q, stat_q, ack_q;
  logic [ADDR_W-1:0] base_q, wr_addr, start_mask;
  logic [7:0]        first_q;
  logic [COL_W-1:0]  col, rd_col, start_col, last_col;
  logic [7:0]        rd_data;
  logic              rd_dirty, busy;
  logic              take_start, take_byte, end_tx, hit_now, go, lock_upd;
  lock_e             lock_st;

  assign take_start = start_i && !busy && !stop_i;
  assign take_byte  = byte_valid_i && active_q && !busy && !stop_i && !start_i;
  assign end_tx     = stop_i && active_q;

  assign start_mask = tgt_i ? ADDR_W'(CTL_PG - 1) : ADDR_W'(ARR_PG - 1);
  assign start_col  = COL_W'(addr_i & start_mask);
  assign last_col   = tgt_q ? CTL_LAST : ARR_LAST;
  assign wr_addr    = base_q | ADDR_W'(col);
  assign hit_now    = (tgt_q == TGT_ARR) && (wr_addr >= prot_lo_i) && (wr_addr <= prot_hi_i);

  // commit only if bytes loaded and neither protection nor lock blocks it
  assign go = end_tx && any_q &&
              !((tgt_q == TGT_ARR) && hit_q) &&
              !((tgt_q == TGT_CTL) && !stat_q && lock_st != LK_OPEN);
  assign lock_upd = end_tx && stat_q && any_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tgt_q    <= TGT_ARR;
      base_q   <= '0;
      any_q    <= 1'b0;
      hit_q    <= 1'b0;
      stat_q   <= 1'b0;
      first_q  <= '0;
      ack_q    <= 1'b0;
    end else begin
      ack_q <= take_byte;
      if (take_start) begin
        active_q <= 1'b1;
        tgt_q    <= tgt_i;
        base_q   <= addr_i & ~start_mask;
        any_q    <= 1'b0;
        hit_q    <= 1'b0;
        stat_q   <= (tgt_i == TGT_CTL) && (addr_i == ADDR_W'(STATUS_ADDR));
      end else if (end_tx) begin
        active_q <= 1'b0;
      end else if (take_byte) begin
        any_q <= 1'b1;
        hit_q <= hit_q | hit_now;
        if (!any_q) first_q <= byte_i;
      end
    end
  end

  pwb_col_ctr #(.ARR_PG(ARR_PG), .CTL_PG(CTL_PG)) u_col (
    .clk_i, .rst_ni,
    .tgt_i      (tgt_q),
    .load_i     (take_start),
    .load_col_i (start_col),
    .adv_i      (take_byte),
    .col_o      (col)
  );

  pwb_page_buf #(.DEPTH(ARR_PG), .DW(8)) u_buf (
    .clk_i, .rst_ni,
    .clear_i    (take_start),
    .wr_i       (take_byte),
    .wr_col_i   (col),
    .wr_data_i  (byte_i),
    .rd_col_i   (rd_col),
    .rd_data_o  (rd_data),
    .rd_dirty_o (rd_dirty)
  );

  pwb_lock u_lock (
    .clk_i, .rst_ni,
    .upd_i (lock_upd),
    .val_i (first_q),
    .st_o  (lock_st)
  );

  pwb_commit_scan #(.ARR_PG(ARR_PG), .ADDR_W(ADDR_W)) u_scan (
    .clk_i, .rst_ni,
    .go_i       (go),
    .last_col_i (last_col),
    .base_i     (base_q),
    .tgt_i      (tgt_q),
    .rd_col_o   (rd_col),
    .rd_data_i  (rd_data),
    .rd_dirty_i (rd_dirty),
    .busy_o     (busy),
    .cm_valid_o,
    .cm_tgt_o,
    .cm_addr_o,
    .cm_data_o
  );

  assign ack_o  = ack_q;
  assign col_o  = col;
  assign lock_o = (lock_st == LK_OPEN);
  assign busy_o = busy;

  AST_ACK_FOLLOWS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(byte_valid_i && active_q)); // R10
  AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ack_o); // R9
  AST_NO_CM_OPEN_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> !cm_valid_o); // R5
  AST_EMPTY_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_tx && !any_q) |=> !busy_o); // R11
  AST_CM_IN_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_valid_o |-> (cm_addr_o & ~(cm_tgt_o ? ADDR_W'(CTL_PG - 1) : ADDR_W'(ARR_PG - 1))) == base_q); // R4
endmodule

// File: tb/tb_page_write_ctrl.sv
`timescale 1ns/1ps
module tb_page_write_ctrl;
  localparam int ADDR_W = 12;
  localparam int COL_W  = 7;
  localparam int NV     = 4;
  localparam int V_ADDR [NV] = '{105, 'h200, 'h17E, 'h280};
  localparam int V_N    [NV] = '{30, 1, 4, 130};
  localparam int V_SEED [NV] = '{'h10, 'hA0, 'h33, 'h00};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, tgt_i = 0, byte_valid_i = 0, stop_i = 0;
  logic [ADDR_W-1:0] addr_i = '0, prot_lo_i = '1, prot_hi_i = '0;
  logic [7:0] byte_i = '0;
  logic ack_o, lock_o, busy_o, cm_valid_o, cm_tgt_o;
  logic [COL_W-1:0] col_o;
  logic [ADDR_W-1:0] cm_addr_o;
  logic [7:0] cm_data_o;

  int checks = 0, errors = 0;
  int log_n = 0, ack_cnt = 0, pre_stop_n;
  int log_addr [256];
  int log_data [256];
  bit log_tgt [256];
  int exp_data [128];
  bit exp_dirty [128];

  always #5 clk = ~clk;

  page_write_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .tgt_i, .addr_i, .byte_valid_i, .byte_i,
    .stop_i, .prot_lo_i, .prot_hi_i, .ack_o, .col_o, .lock_o, .busy_o,
    .cm_valid_o, .cm_tgt_o, .cm_addr_o, .cm_data_o
  );

  always @(negedge clk) begin
    if (ack_o) ack_cnt++;
    if (cm_valid_o && log_n < 256) begin
      log_addr[log_n] = int'(cm_addr_o);
      log_data[log_n] = int'(cm_data_o);
      log_tgt[log_n]  = cm_tgt_o;
      log_n++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_tx(input bit tgt, input int addr, input int n, input int seed);
    log_n = 0; ack_cnt = 0;
    @(negedge clk); start_i = 1; tgt_i = tgt; addr_i = ADDR_W'(addr);
    @(negedge clk); start_i = 0;
    for (int i = 0; i < n; i++) begin
      byte_valid_i = 1; byte_i = 8'(seed + i);
      @(negedge clk);
    end
    byte_valid_i = 0;
    pre_stop_n = log_n;
    stop_i = 1;
    @(negedge clk); stop_i = 0;
    for (int w = 0; w < 400 && busy_o; w++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic build_exp(input bit tgt, input int addr, input int n, input int seed);
    int p = tgt ? 8 : 128;
    for (int c = 0; c < 128; c++) begin exp_dirty[c] = 0; exp_data[c] = 0; end
    for (int i = 0; i < n; i++) begin
      exp_dirty[((addr % p) + i) % p] = 1;
      exp_data[((addr % p) + i) % p]  = (seed + i) & 'hFF;
    end
  endtask

  task automatic chk_commits(input string req, input bit tgt, input int addr);
    int p = tgt ? 8 : 128;
    int base = addr - (addr % p);
    int k = 0;
    int cnt = 0;
    for (int c = 0; c < p; c++) if (exp_dirty[c]) cnt++;
    chk({req, " commit count"}, log_n, cnt);
    for (int c = 0; c < p; c++) begin
      if (exp_dirty[c] && k < log_n) begin
        chk({req, " addr"}, log_addr[k], base + c);
        chk({req, " data"}, log_data[k], exp_data[c]);
        chk({req, " tgt"}, int'(log_tgt[k]), int'(tgt));
        k++;
      end
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ack", int'(ack_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 cm_valid", int'(cm_valid_o), 0);
    chk("R1 lock", int'(lock_o), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4 R5 R10: array vector table
    for (int v = 0; v < NV; v++) begin
      run_tx(0, V_ADDR[v], V_N[v], V_SEED[v]);
      build_exp(0, V_ADDR[v], V_N[v], V_SEED[v]);
      chk("R5 no commit before stop", pre_stop_n, 0);
      chk("R10 ack count", ack_cnt, V_N[v]);
      chk("R2 col after load", int'(col_o), ((V_ADDR[v] % 128) + V_N[v]) % 128);
      chk_commits("R3 R4 array", 0, V_ADDR[v]);
    end

    // R8 protected range
    prot_lo_i = 12'h300; prot_hi_i = 12'h30F;
    run_tx(0, 'h305, 2, 'h55);
    chk("R8 protected acked", ack_cnt, 2);
    chk("R8 protected dropped", log_n, 0);
    run_tx(0, 'h310, 2, 'h66);
    build_exp(0, 'h310, 2, 'h66);
    chk_commits("R8 outside range", 0, 'h310);
    prot_lo_i = '1; prot_hi_i = '0;

    // R7 locked control write dropped
    run_tx(1, 'h010, 3, 'h20);
    chk("R7 locked acked", ack_cnt, 3);
    chk("R7 locked dropped", log_n, 0);
    // R6 unlock sequence
    run_tx(1, 'h03F, 1, 'h02);
    chk("R6 status commits", log_n, 1);
    chk("R6 step one not open", int'(lock_o), 0);
    run_tx(1, 'h03F, 1, 'h06);
    chk("R6 open after 02,06", int'(lock_o), 1);
    // R7 R2 R3 unlocked control page write with wrap and overwrite
    run_tx(1, 'h012, 10, 'h40);
    build_exp(1, 'h012, 10, 'h40);
    chk("R2 ctl col wrap", int'(col_o), 4);
    chk_commits("R7 R3 ctl unlocked", 1, 'h012);
    // R6 wrong key relocks
    run_tx(1, 'h03F, 1, 'h02);
    run_tx(1, 'h03F, 1, 'h05);
    chk("R6 wrong value relocks", int'(lock_o), 0);
    run_tx(1, 'h010, 1, 'h77);
    chk("R7 relocked dropped", log_n, 0);
    run_tx(1, 'h03F, 1, 'h06);
    chk("R6 06 without step stays locked", int'(lock_o), 0);

    // R9 ignored while busy
    run_tx(0, 'h400, 0, 0);
    log_n = 0; ack_cnt = 0;
    @(negedge clk); start_i = 1; tgt_i = 0; addr_i = 12'h400;
    @(negedge clk); start_i = 0; byte_valid_i = 1; byte_i = 8'h11;
    @(negedge clk); byte_i = 8'h12;
    @(negedge clk); byte_valid_i = 0; stop_i = 1;
    @(negedge clk); stop_i = 0;
    chk("R9 busy after stop", int'(busy_o), 1);
    start_i = 1; addr_i = 12'h520;
    @(negedge clk); start_i = 0; byte_valid_i = 1; byte_i = 8'hEE;
    @(negedge clk); @(negedge clk); byte_valid_i = 0;
    for (int w = 0; w < 400 && busy_o; w++) @(negedge clk);
    @(negedge clk);
    chk("R9 acks only accepted", ack_cnt, 2);
    chk("R9 col unchanged", int'(col_o), 2);
    build_exp(0, 'h400, 2, 'h11);
    chk_commits("R9 original commit", 0, 'h400);
    // R9 byte with no open transaction
    ack_cnt = 0;
    @(negedge clk); byte_valid_i = 1; byte_i = 8'h99;
    @(negedge clk); byte_valid_i = 0;
    @(negedge clk);
    chk("R9 idle byte no ack", ack_cnt, 0);
    chk("R9 idle byte col", int'(col_o), 2);

    // R11 empty transaction
    log_n = 0;
    @(negedge clk); start_i = 1; tgt_i = 0; addr_i = 12'h600;
    @(negedge clk); start_i = 0; stop_i = 1;
    @(negedge clk); stop_i = 0;
    chk("R11 no busy", int'(busy_o), 0);
    repeat (3) @(negedge clk);
    chk("R11 no commit", log_n, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule